// File: doc/BRIEF.md
# Execute-Stage Operand Forwarding Unit

This block chooses the two ALU operands for the execute stage of a five-stage in-order integer pipeline. For each operand it compares the source register number of the instruction in execute with the destination register numbers of the two older instructions. One older instruction sits in the execute/memory pipeline register. The other sits in the memory/writeback pipeline register. Each comparison counts only when that older instruction actually writes a register. The result is a two-bit select for each operand. A pair of multiplexers then uses the select to pass one of three values to the ALU: the register-file read data, the ALU result held in execute/memory, or the value being written back.

The whole block is combinational and has no clock or reset. When both older instructions write the register an operand needs, the execute/memory one is the newer and its value is used. Register zero always reads as zero, so a write aimed at it is never forwarded. The two operands are resolved independently of each other.

Top module: `fwd_unit`

## Requirements
- R1: When neither older stage qualifies for an operand, that operand's select is 00 and the operand equals its register-file read data.
- R2: When the execute/memory stage has its write flag set, a nonzero destination, and that destination equals the first source register, `sel_a` is 10 and `op_a` equals `exm_result`.
- R3: The same execute/memory condition applied to the second source register gives `sel_b` = 10 and `op_b` = `exm_result`.
- R4: When only the memory/writeback stage qualifies (write flag set, nonzero destination, destination equal to the operand's source), the select is 01 and the operand equals `wb_value`.
- R5: When both stages qualify for the same operand, the select is 10 and the operand takes the execute/memory value.
- R6: A stage whose write flag is low never forwards, even on a register match. If the other stage qualifies, that stage supplies the operand.
- R7: A destination register number of zero never forwards, whatever the write flag. A source register number of zero always yields select 00.
- R8: Operands A and B are resolved independently, so in one cycle they may use different sources (for example A at 10 and B at 01).
- R9: The select outputs never carry 11. The operand multiplexer, given code 11, passes the register-file data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_a | input | 5 | First source register number of the instruction in execute |
| src_b | input | 5 | Second source register number of the instruction in execute |
| exm_dst | input | 5 | Destination register number held in execute/memory |
| exm_wr | input | 1 | Register-write flag held in execute/memory |
| mwb_dst | input | 5 | Destination register number held in memory/writeback |
| mwb_wr | input | 1 | Register-write flag held in memory/writeback |
| rf_a | input | 32 | Register-file read data for operand A |
| rf_b | input | 32 | Register-file read data for operand B |
| exm_result | input | 32 | ALU result held in execute/memory |
| wb_value | input | 32 | Value being written back from memory/writeback |
| sel_a | output | 2 | Operand A select: 00 register file, 01 writeback, 10 execute/memory |
| sel_b | output | 2 | Operand B select, same coding |
| op_a | output | 32 | Chosen ALU operand A |
| op_b | output | 32 | Chosen ALU operand B |

## Verification
The block holds no state, so any fault in the match or priority logic appears on `sel_a`/`sel_b` and on the operands in the same cycle as the stimulus. The cases that reveal faults are a zero destination with the write flag set, a write flag that is low while the registers match, and both stages matching one operand. Each of these changes a select away from the value the requirements give. Mixing A and B sources in one cycle shows whether the two operand paths leak into each other. The reserved select code is applied directly to a standalone multiplexer, because it cannot be reached from the top-level ports.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
    localparam int REG_AW  = 5;
    localparam int DATA_W  = 32;
    localparam int NUM_OPS = 2;

    typedef enum logic [1:0] {
        SEL_REGFILE = 2'b00,
        SEL_WBACK   = 2'b01,
        SEL_EXMEM   = 2'b10,
        SEL_RSVD    = 2'b11
    } fwd_sel_e;
endpackage

// File: rtl/fwd_match.sv
// One producer-versus-consumer comparison: a hit needs a real write to a
// nonzero register that equals the consumer's source register.
module fwd_match #(
    parameter int REG_AW = fwd_pkg::REG_AW
) (
    input  logic [REG_AW-1:0] src,
    input  logic [REG_AW-1:0] dst,
    input  logic              wr,
    output logic              hit
);
    logic dst_live;

    always_comb begin
        dst_live = wr && (dst != '0);
        hit      = dst_live && (dst == src);
    end
endmodule

// File: rtl/fwd_select.sv
// Per-operand select with newest-producer priority.
module fwd_select #(
    parameter int REG_AW = fwd_pkg::REG_AW
) (
    input  logic [REG_AW-1:0] src,
    input  logic [REG_AW-1:0] exm_dst,
    input  logic              exm_wr,
    input  logic [REG_AW-1:0] mwb_dst,
    input  logic              mwb_wr,
    output fwd_pkg::fwd_sel_e sel
);
    import fwd_pkg::*;

    logic exm_hit;
    logic mwb_hit;

    fwd_match #(.REG_AW(REG_AW)) exm_match_i (
        .src (src),
        .dst (exm_dst),
        .wr  (exm_wr),
        .hit (exm_hit)
    );

    fwd_match #(.REG_AW(REG_AW)) mwb_match_i (
        .src (src),
        .dst (mwb_dst),
        .wr  (mwb_wr),
        .hit (mwb_hit)
    );

    always_comb begin
        unique case ({exm_hit, mwb_hit})
            2'b10, 2'b11: sel = SEL_EXMEM;
            2'b01:        sel = SEL_WBACK;
            default:      sel = SEL_REGFILE;
        endcase
    end

    always_comb begin
        if (exm_hit && mwb_hit)
            assert_newest_wins_R5: assert (sel == SEL_EXMEM);
        if (src == '0)
            assert_zero_src_R7: assert (sel == SEL_REGFILE);
        if (!exm_wr && !mwb_wr)
            assert_no_writer_R6: assert (sel == SEL_REGFILE);
        assert_no_rsvd_R9: assert (sel != SEL_RSVD);
    end
endmodule

// File: rtl/fwd_operand_mux.sv
// Three-way operand mux; the reserved code falls back to register-file data.
module fwd_operand_mux #(
    parameter int DATA_W = fwd_pkg::DATA_W
) (
    input  logic [1:0]        sel,
    input  logic [DATA_W-1:0] rf_data,
    input  logic [DATA_W-1:0] exm_data,
    input  logic [DATA_W-1:0] wb_data,
    output logic [DATA_W-1:0] operand
);
    import fwd_pkg::*;

    always_comb begin
        case (sel)
            SEL_EXMEM: operand = exm_data;
            SEL_WBACK: operand = wb_data;
            default:   operand = rf_data;
        endcase
    end
endmodule

// File: rtl/fwd_unit.sv
module fwd_unit #(
    parameter int REG_AW = fwd_pkg::REG_AW,
    parameter int DATA_W = fwd_pkg::DATA_W
) (
    input  logic [REG_AW-1:0] src_a,
    input  logic [REG_AW-1:0] src_b,
    input  logic [REG_AW-1:0] exm_dst,
    input  logic              exm_wr,
    input  logic [REG_AW-1:0] mwb_dst,
    input  logic              mwb_wr,
    input  logic [DATA_W-1:0] rf_a,
    input  logic [DATA_W-1:0] rf_b,
    input  logic [DATA_W-1:0] exm_result,
    input  logic [DATA_W-1:0] wb_value,
    output logic [1:0]        sel_a,
    output logic [1:0]        sel_b,
    output logic [DATA_W-1:0] op_a,
    output logic [DATA_W-1:0] op_b
);
    import fwd_pkg::*;

    localparam int OPS = NUM_OPS;

    logic [REG_AW-1:0] src_arr [OPS];
    logic [DATA_W-1:0] rf_arr  [OPS];
    logic [DATA_W-1:0] op_arr  [OPS];
    fwd_sel_e          sel_arr [OPS];

    always_comb begin
        src_arr[0] = src_a;
        src_arr[1] = src_b;
        rf_arr[0]  = rf_a;
        rf_arr[1]  = rf_b;
    end

    for (genvar k = 0; k < OPS; k++) begin : g_operand
        fwd_select #(.REG_AW(REG_AW)) sel_i (
            .src     (src_arr[k]),
            .exm_dst (exm_dst),
            .exm_wr  (exm_wr),
            .mwb_dst (mwb_dst),
            .mwb_wr  (mwb_wr),
            .sel     (sel_arr[k])
        );

        fwd_operand_mux #(.DATA_W(DATA_W)) mux_i (
            .sel      (sel_arr[k]),
            .rf_data  (rf_arr[k]),
            .exm_data (exm_result),
            .wb_data  (wb_value),
            .operand  (op_arr[k])
        );
    end

    always_comb begin
        sel_a = sel_arr[0];
        sel_b = sel_arr[1];
        op_a  = op_arr[0];
        op_b  = op_arr[1];
    end

    // Port-level relations between the select stage and the mux stage.
    always_comb begin
        if (sel_a == SEL_REGFILE)
            assert_passthru_a_R1: assert (op_a == rf_a);
        if (sel_b == SEL_REGFILE)
            assert_passthru_b_R1: assert (op_b == rf_b);
        if (exm_wr && exm_dst != '0 && exm_dst == src_a)
            assert_exm_fwd_a_R2: assert (op_a == exm_result);
        if (exm_wr && exm_dst != '0 && exm_dst == src_b)
            assert_exm_fwd_b_R3: assert (op_b == exm_result);
        if (sel_a == SEL_WBACK)
            assert_wb_fwd_a_R4: assert (op_a == wb_value);
        if (sel_b == SEL_WBACK)
            assert_wb_fwd_b_R4: assert (op_b == wb_value);
    end
endmodule

// File: tb/fwd_unit_tb_top.sv
module fwd_unit_tb_top;
    localparam int AW = 5;
    localparam int DW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [AW-1:0] src_a, src_b, exm_dst, mwb_dst;
    logic          exm_wr, mwb_wr;
    logic [DW-1:0] rf_a, rf_b, exm_result, wb_value;
    logic [1:0]    sel_a, sel_b;
    logic [DW-1:0] op_a, op_b;

    logic [1:0]    mx_sel;
    logic [DW-1:0] mx_out;

    fwd_unit dut_i (
        .src_a(src_a), .src_b(src_b), .exm_dst(exm_dst), .exm_wr(exm_wr),
        .mwb_dst(mwb_dst), .mwb_wr(mwb_wr), .rf_a(rf_a), .rf_b(rf_b),
        .exm_result(exm_result), .wb_value(wb_value),
        .sel_a(sel_a), .sel_b(sel_b), .op_a(op_a), .op_b(op_b)
    );

    fwd_operand_mux #(.DATA_W(DW)) mux_chk_i (
        .sel(mx_sel), .rf_data(32'h1111_0000), .exm_data(32'h2222_0000),
        .wb_data(32'h3333_0000), .operand(mx_out)
    );

    typedef struct {
        string         tag;
        logic [1:0]    sa, sb;
        logic [DW-1:0] oa, ob;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_errors = 0;
    bit   finished = 0;

    function automatic logic [1:0] model_sel(logic [AW-1:0] s, logic [AW-1:0] ed,
                                             logic ew, logic [AW-1:0] md, logic mw);
        if (ew && ed != 0 && ed == s) return 2'b10;
        if (mw && md != 0 && md == s) return 2'b01;
        return 2'b00;
    endfunction

    function automatic logic [DW-1:0] model_op(logic [1:0] s, logic [DW-1:0] rf);
        if (s == 2'b10) return exm_result;
        if (s == 2'b01) return wb_value;
        return rf;
    endfunction

    task automatic check(string tag, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic drive(string tag, logic [AW-1:0] sa, logic [AW-1:0] sb,
                         logic [AW-1:0] ed, logic ew, logic [AW-1:0] md, logic mw);
        exp_t e;
        @(negedge clk);
        src_a = sa; src_b = sb; exm_dst = ed; exm_wr = ew; mwb_dst = md; mwb_wr = mw;
        rf_a = 32'hA000_0000 | 32'(sa); rf_b = 32'hB000_0000 | 32'(sb);
        exm_result = 32'hE000_0000 | 32'(ed); wb_value = 32'hC000_0000 | 32'(md);
        e.tag = tag;
        e.sa = model_sel(sa, ed, ew, md, mw);
        e.sb = model_sel(sb, ed, ew, md, mw);
        e.oa = model_op(e.sa, rf_a);
        e.ob = model_op(e.sb, rf_b);
        exp_q.push_back(e);
    endtask

    // Monitor: compare design outputs with the queued expectations.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (rst_n && exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                check(e.tag, "sel_a", 32'(sel_a), 32'(e.sa));
                check(e.tag, "sel_b", 32'(sel_b), 32'(e.sb));
                check(e.tag, "op_a", op_a, e.oa);
                check(e.tag, "op_b", op_b, e.ob);
            end
        end
    end

    initial begin
        #1_000_000;
        if (!finished) begin
            finished = 1;
            n_checks++; n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        src_a = 0; src_b = 0; exm_dst = 0; exm_wr = 0; mwb_dst = 0; mwb_wr = 0;
        rf_a = 0; rf_b = 0; exm_result = 0; wb_value = 0; mx_sel = 2'b00;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        drive("R1", 5'd0, 5'd0, 5'd0, 1'b0, 5'd0, 1'b0);      // idle state
        drive("R1", 5'd3, 5'd4, 5'd7, 1'b1, 5'd9, 1'b1);      // no match
        drive("R2", 5'd6, 5'd4, 5'd6, 1'b1, 5'd0, 1'b0);
        drive("R3", 5'd4, 5'd6, 5'd6, 1'b1, 5'd0, 1'b0);
        drive("R4", 5'd8, 5'd2, 5'd1, 1'b1, 5'd8, 1'b1);
        drive("R4", 5'd2, 5'd8, 5'd0, 1'b0, 5'd8, 1'b1);
        drive("R5", 5'd1, 5'd1, 5'd1, 1'b1, 5'd1, 1'b1);      // double hazard
        drive("R6", 5'd5, 5'd5, 5'd5, 1'b0, 5'd5, 1'b1);      // older wins if newer not writing
        drive("R6", 5'd5, 5'd5, 5'd5, 1'b0, 5'd5, 1'b0);
        drive("R7", 5'd0, 5'd0, 5'd0, 1'b1, 5'd0, 1'b1);
        drive("R7", 5'd0, 5'd3, 5'd0, 1'b1, 5'd3, 1'b1);      // zero dst falls to wb
        drive("R8", 5'd10, 5'd11, 5'd10, 1'b1, 5'd11, 1'b1);
        drive("R8", 5'd11, 5'd10, 5'd10, 1'b1, 5'd11, 1'b1);
        drive("R8", 5'd31, 5'd12, 5'd12, 1'b1, 5'd31, 1'b1);

        for (int i = 0; i < 300; i++) begin
            drive("R9", 5'($urandom_range(0, 3)), 5'($urandom_range(0, 3)),
                  5'($urandom_range(0, 3)), 1'($urandom), 5'($urandom_range(0, 3)), 1'($urandom));
        end

        wait (exp_q.size() == 0);
        @(negedge clk);

        // Standalone multiplexer: every code, including the reserved one (R9).
        mx_sel = 2'b00; #2; check("R1", "mux 00", mx_out, 32'h1111_0000);
        mx_sel = 2'b10; #2; check("R2", "mux 10", mx_out, 32'h2222_0000);
        mx_sel = 2'b01; #2; check("R4", "mux 01", mx_out, 32'h3333_0000);
        mx_sel = 2'b11; #2; check("R9", "mux 11", mx_out, 32'h1111_0000);

        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule